// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-rank SDR SDRAM out of power-up. It drives the chip-select, row-strobe, column-strobe, write-enable, clock-enable, byte-mask, bank and address pins from reset until the memory is ready for normal use. Reset starts the sequence. The block first idles through a power-up pause whose length in cycles comes from the clock frequency and pause duration parameters. It then closes every bank with a single precharge and runs a fixed number of auto-refresh commands (eight by default). Last, it loads the mode register from a parameter value. The block keeps each command-to-command spacing by inserting NOPs.

When the guard after the mode load has run out, the block raises `init_done` and releases the byte masks. After that it leaves the bus idle, so a controller can take over the command pins. A synchronous reset at any time drops `init_done` and starts the whole sequence again.

Top module: `sdram_bringup_seq`

## Requirements
- R1: During reset and the power-up pause the pins carry NOP (chip select low; row strobe, column strobe and write enable high), both byte masks are high and `init_done` is low.
- R2: The first command other than NOP is precharge-all: row strobe low, column strobe high, write enable low, address bit 10 high. It appears on the clock edge numbered CLK_MHZ*PAUSE_US, counting the first edge with reset low as edge 1.
- R3: Exactly REF_COUNT auto-refresh commands are issued (row and column strobes low, write enable high). The first comes T_RP cycles after the precharge-all.
- R4: Each further auto-refresh follows the previous one by T_RFC cycles. The mode-register set follows the last refresh by T_RFC cycles.
- R5: The mode-register set drives chip select and all three strobes low, with MODE_VALUE on the address pins and bank select zero.
- R6: Clock enable is high in every cycle, both during reset and after it.
- R7: `init_done` rises T_RSC+1 cycles after the mode-register set and then stays high. In the same cycle both byte masks go low, and only NOPs appear from the mode-register set onward.
- R8: Reset asserted at any point, even mid-refresh or after `init_done`, shows NOP, high masks and low `init_done` on the next cycle. The full sequence then repeats with the same timing once reset is released.
- R9: Over a complete sequence the block issues exactly one precharge-all, REF_COUNT refreshes and one mode-register set, in that order, and no other command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high, restarts the sequence |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Byte masks, high until ready |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address pins (A10 precharge-all, mode value) |
| init_done | output | 1 | Device initialized, sticky until reset |

## Verification
The hardest situation to reach from the ports is a reset that lands in the middle of the refresh train. At that point the refresh counter and the wait timer both hold values that are partly used. The bench runs the sequence until several refreshes have gone out, asserts reset between two of them, and checks the idle pins on the following cycle. It then times a second complete sequence against the same expected table, which shows that no leftover count shortens the pause or the refresh train. A reset after `init_done` is also covered, to show the ready flag and the masks return to their pre-ready levels.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

    // Command selected for the current cycle
    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_REFRESH,
        CMD_MODESET
    } cmd_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_WAIT_RP,
        ST_WAIT_RFC,
        ST_WAIT_RSC,
        ST_READY
    } state_e;

endpackage

// File: rtl/sdram_init_timer.sv
// Down counter shared by every wait phase; reset preloads the pause length.
module sdram_init_timer #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= RST_VAL;
        else     cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_pins.sv
// Maps the registered command and ready flag onto the memory pins.
module sdram_init_pins
    import sdram_bringup_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int DQM_W   = 2,
    parameter int PALL_BIT = 10,
    parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
    input  cmd_e              cmd,
    input  logic              ready,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_PRECHARGE: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                addr[PALL_BIT] = 1'b1;
            end
            CMD_REFRESH: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MODESET: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = MODE_VALUE;
            end
            default: ;
        endcase
    end

    assign cke = 1'b1;
    assign dqm = {DQM_W{~ready}};
endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
    import sdram_bringup_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int PAUSE_US  = 200,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 8,
    parameter int T_RSC     = 2,
    parameter int REF_COUNT = 8,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter int DQM_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_VALUE = 'h030
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int MAX_A     = (PAUSE_CYC > T_RFC) ? PAUSE_CYC : T_RFC;
    localparam int MAX_B     = (T_RP > T_RSC + 1) ? T_RP : T_RSC + 1;
    localparam int MAX_WAIT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam int REF_W     = $clog2(REF_COUNT + 1);

    typedef struct packed {
        state_e           st;
        cmd_e             cmd;
        logic [REF_W-1:0] refs;
        logic             ready;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_PAUSE, cmd: CMD_NOP, refs: '0, ready: 1'b0};

    seq_t             s_d, s_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (CNT_W'(PAUSE_CYC - 1))
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.st)
            ST_PAUSE: if (tmr_zero) begin
                s_d.cmd  = CMD_PRECHARGE;
                s_d.st   = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RP - 1);
            end
            ST_WAIT_RP: if (tmr_zero) begin
                s_d.cmd  = CMD_REFRESH;
                s_d.refs = REF_W'(1);
                s_d.st   = ST_WAIT_RFC;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RFC - 1);
            end
            ST_WAIT_RFC: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (s_q.refs == REF_W'(REF_COUNT)) begin
                    s_d.cmd = CMD_MODESET;
                    s_d.st  = ST_WAIT_RSC;
                    tmr_val = CNT_W'(T_RSC);
                end else begin
                    s_d.cmd  = CMD_REFRESH;
                    s_d.refs = s_q.refs + 1'b1;
                    tmr_val  = CNT_W'(T_RFC - 1);
                end
            end
            ST_WAIT_RSC: if (tmr_zero) begin
                s_d.st    = ST_READY;
                s_d.ready = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= SEQ_RST;
        else     s_q <= s_d;
    end

    sdram_init_pins #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .DQM_W      (DQM_W),
        .PALL_BIT   (10),
        .MODE_VALUE (MODE_VALUE)
    ) u_pins (
        .cmd   (s_q.cmd),
        .ready (s_q.ready),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n),
        .cke   (sd_cke),
        .dqm   (sd_dqm),
        .ba    (sd_ba),
        .addr  (sd_addr)
    );

    assign init_done = s_q.ready;
endmodule

// File: rtl/sdram_bringup_chk.sv
module sdram_bringup_chk #(
    parameter int REF_COUNT = 8,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter int DQM_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic              sd_cke,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);
    localparam int SEEN_W = $clog2(REF_COUNT + 2);

    logic is_nop, is_pre, is_ref, is_mrs;
    logic [SEEN_W-1:0] refs_seen;

    assign is_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
    assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
    assign is_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;

    always_ff @(posedge clk) begin
        if (rst)         refs_seen <= '0;
        else if (is_ref) refs_seen <= refs_seen + 1'b1;
    end

    a_r1_masks_before_ready: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (sd_dqm == '1) && sd_cke);

    a_r2_precharge_all_bit: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> sd_addr[10]);

    a_r3_refresh_bound: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (refs_seen < SEEN_W'(REF_COUNT)));

    a_r4_modeset_after_refreshes: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (refs_seen == SEEN_W'(REF_COUNT)));

    a_r5_mode_value: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (sd_addr == MODE_VALUE) && (sd_ba == '0));

    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r7_idle_when_ready: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop && (sd_dqm == '0));
endmodule

bind sdram_bringup_seq sdram_bringup_chk #(
    .REF_COUNT  (REF_COUNT),
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .DQM_W      (DQM_W),
    .MODE_VALUE (MODE_VALUE)
) u_chk (.*);

// File: tb/sdram_bringup_seq_test.sv
module sdram_bringup_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int PAUSE_US   = 200;
    localparam int T_RP       = 3;
    localparam int T_RFC      = 7;
    localparam int T_RSC      = 2;
    localparam int REF_COUNT  = 8;
    localparam int ADDR_W     = 13;
    localparam int BA_W       = 2;
    localparam int DQM_W      = 2;
    localparam logic [ADDR_W-1:0] MODE_VALUE = 13'h0233;

    localparam int PAUSE = CLK_MHZ * PAUSE_US;
    localparam int T_MRS = PAUSE + T_RP + (REF_COUNT - 1) * T_RFC + T_RFC;
    localparam int T_DONE = T_MRS + T_RSC + 1;
    localparam int N_EV = REF_COUNT + 2;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    typedef struct packed {
        int         t;
        logic [3:0] code;
    } ev_s;

    localparam ev_s EXP [N_EV] = '{
        '{PAUSE,                      C_PRE},
        '{PAUSE + T_RP,               C_REF},
        '{PAUSE + T_RP + 1 * T_RFC,   C_REF},
        '{PAUSE + T_RP + 2 * T_RFC,   C_REF},
        '{PAUSE + T_RP + 3 * T_RFC,   C_REF},
        '{PAUSE + T_RP + 4 * T_RFC,   C_REF},
        '{PAUSE + T_RP + 5 * T_RFC,   C_REF},
        '{PAUSE + T_RP + 6 * T_RFC,   C_REF},
        '{PAUSE + T_RP + 7 * T_RFC,   C_REF},
        '{T_MRS,                      C_MRS}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, init_done;
    logic [DQM_W-1:0]  sd_dqm;
    logic [BA_W-1:0]   sd_ba;
    logic [ADDR_W-1:0] sd_addr;

    sdram_bringup_seq #(
        .CLK_MHZ (CLK_MHZ), .PAUSE_US (PAUSE_US), .T_RP (T_RP), .T_RFC (T_RFC),
        .T_RSC (T_RSC), .REF_COUNT (REF_COUNT), .ADDR_W (ADDR_W), .BA_W (BA_W),
        .DQM_W (DQM_W), .MODE_VALUE (MODE_VALUE)
    ) uut (
        .clk (clk), .rst (rst), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_cke (sd_cke),
        .sd_dqm (sd_dqm), .sd_ba (sd_ba), .sd_addr (sd_addr), .init_done (init_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Observation log
    int         ev_t [N_EV + 4];
    logic [3:0] ev_c [N_EV + 4];
    logic [ADDR_W-1:0] ev_a [N_EV + 4];
    logic [BA_W-1:0]   ev_b [N_EV + 4];
    int n_ev, done_t, cke_bad, dqm_bad, done_drop;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reset for a few cycles and check the idle pins while held (R1, R6)
    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (n) @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "reset cmd",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
        check(sd_dqm == '1 && !init_done, "R1", "reset dqm/done",
              int'({sd_dqm, init_done}), int'({{DQM_W{1'b1}}, 1'b0}));
        check(sd_cke, "R6", "reset cke", int'(sd_cke), 1);
        rst = 1'b0;
    endtask

    // Sample ncyc cycles after reset release; cycle t follows edge t
    task automatic observe(input int ncyc);
        logic [3:0] code;
        n_ev = 0; done_t = -1; cke_bad = 0; dqm_bad = 0; done_drop = 0;
        for (int t = 1; t <= ncyc; t++) begin
            @(negedge clk);
            code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (code != C_NOP) begin
                if (n_ev < N_EV + 4) begin
                    ev_t[n_ev] = t; ev_c[n_ev] = code;
                    ev_a[n_ev] = sd_addr; ev_b[n_ev] = sd_ba;
                end
                n_ev++;
            end
            if (!sd_cke) cke_bad++;
            if (init_done && done_t < 0) done_t = t;
            if (done_t >= 0 && !init_done) done_drop++;
            if (sd_dqm != {DQM_W{~init_done}}) dqm_bad++;
        end
    endtask

    task automatic check_full_sequence(input string tag);
        check(n_ev == N_EV, "R9", {tag, " command count"}, n_ev, N_EV);
        for (int i = 0; i < N_EV && i < n_ev; i++) begin
            check(ev_c[i] == EXP[i].code, (i == 0) ? "R2" : (i == N_EV - 1) ? "R5" : "R3",
                  {tag, " command code"}, int'(ev_c[i]), int'(EXP[i].code));
            check(ev_t[i] == EXP[i].t, (i < 2) ? "R2" : "R4",
                  {tag, " command cycle"}, ev_t[i], EXP[i].t);
        end
        if (n_ev >= N_EV) begin
            check(ev_a[0][10] == 1'b1, "R2", {tag, " precharge A10"}, int'(ev_a[0][10]), 1);
            check(ev_a[N_EV-1] == MODE_VALUE && ev_b[N_EV-1] == '0, "R5",
                  {tag, " mode value"}, int'(ev_a[N_EV-1]), int'(MODE_VALUE));
        end
        check(done_t == T_DONE, "R7", {tag, " ready cycle"}, done_t, T_DONE);
        check(done_drop == 0, "R7", {tag, " ready sticky"}, done_drop, 0);
        check(dqm_bad == 0, "R7", {tag, " masks follow ready"}, dqm_bad, 0);
        check(cke_bad == 0, "R6", {tag, " cke held"}, cke_bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // Sequence from power-up reset
        do_reset(3);
        observe(T_DONE + 30);
        check_full_sequence("first");

        // Reset in the middle of the refresh train (R8)
        do_reset(2);
        observe(PAUSE + T_RP + 2 * T_RFC + 2);
        check(n_ev == 4, "R8", "events before mid reset", n_ev, 4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R8", "mid reset cmd",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
        check(sd_dqm == '1 && !init_done, "R8", "mid reset dqm/done",
              int'({sd_dqm, init_done}), int'({{DQM_W{1'b1}}, 1'b0}));
        rst = 1'b0;
        observe(T_DONE + 10);
        check_full_sequence("after mid reset");

        // Reset after ready (R8)
        @(negedge clk);
        check(init_done == 1'b1, "R7", "ready before late reset", int'(init_done), 1);
        rst = 1'b1;
        @(negedge clk);
        check(!init_done && sd_dqm == '1, "R8", "late reset drops ready",
              int'({sd_dqm, init_done}), int'({{DQM_W{1'b1}}, 1'b0}));
        rst = 1'b0;
        observe(PAUSE - 1);
        check(n_ev == 0, "R1", "nop through pause", n_ev, 0);
        check(dqm_bad == 0 && done_t < 0, "R1", "masks high in pause", dqm_bad, 0);
        observe(1);
        check(n_ev == 1 && ev_c[0] == C_PRE, "R2", "precharge ends pause",
              int'(ev_c[0]), int'(C_PRE));

        report();
    end
endmodule